// File: doc/BRIEF.md
# Reconfiguration Microcode Sequencer

This unit runs short microprograms that steer a configurable processing unit. A start request carries a mode bit, an address and a phase. With the mode bit clear, the address is a direct location inside the control-store section picked by the phase. With the mode bit set, the address is an external memory location. That location is looked up in a small fully associative residence table. A hit points at the microprogram's pageable slot. A miss evicts the least recently used entry, copies the microprogram word by word from memory into that entry's slot, and then runs it.

The control store is one synchronous memory with two sections: phase 0 selects the set section and phase 1 the execute section. Each section starts with a fixed resident area, which is filled after power-up through a boot write port. The pageable slots follow it, one for each residence-table entry. Every step goes through the same path. The address register is loaded, the store is read, and the word is captured in the microinstruction register, which then drives the configurable unit for exactly one cycle.

Top module: `ucode_seq`

## Requirements
- R1: After reset, busy, fu_valid, done and mem_req are all low.
- R2: A start with start_rp=0 runs the program at section offset start_addr[5:0], in the set section for start_phase=0 and the execute section for start_phase=1. The first microinstruction is presented on fu_valid in the third cycle after the start is sampled, and each later one follows three cycles after the previous one.
- R3: A microinstruction word has the next-address mode in bits [16:15], a jump target in bits [14:8] and the control field in bits [7:0]. Mode 0 steps to the next word. Mode 1 jumps to the program's first address plus the target.
- R4: Mode 2 jumps like mode 1 when fu_status is high in the cycle the word is presented, and otherwise steps to the next word.
- R5: Mode 3 ends the program. done is high for exactly one cycle, in the cycle after the end word is presented, and busy is low from that cycle on.
- R6: A start with start_rp=1 that misses the table raises mem_req for one memory word per acknowledged cycle, starting at start_addr and counting upward, until an end word has been copied. The copied program then runs.
- R7: A start with start_rp=1 that hits the table runs the resident copy without raising mem_req.
- R8: The table has 4 entries. An empty entry is filled first. Once all are full, a miss replaces the entry used least recently, where both a hit and a completed copy count as a use.
- R9: The table tag includes the phase, so the same memory address under another phase is a miss.
- R10: A copy stops after 8 words even without an end word, and the 8th stored word then acts as an end word.
- R11: A start raised while busy has no effect on the running program.
- R12: Boot writes land only in the fixed area of a section (offsets 0 to 31). Writes aimed at the pageable area are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled when idle |
| start_rp | input | 1 | 0: direct store address, 1: memory address to translate |
| start_phase | input | 1 | 0: set section, 1: execute section |
| start_addr | input | 16 | Section offset or memory address |
| fu_status | input | 1 | Condition from the configurable unit for branches |
| fu_valid | output | 1 | Control field is valid this cycle |
| fu_ctrl | output | 8 | Control field to the configurable unit |
| done | output | 1 | One-cycle pulse after the end word |
| busy | output | 1 | Sequencer not idle |
| mem_req | output | 1 | Microcode word requested from memory |
| mem_addr | output | 16 | Memory address of the requested word |
| mem_ack | input | 1 | Memory returns mem_rdata this cycle |
| mem_rdata | input | 17 | Microinstruction word from memory |
| boot_we | input | 1 | Boot write enable for the fixed areas |
| boot_addr | input | 7 | Control-store address of the boot write |
| boot_data | input | 17 | Boot write data |

## Verification
The assertions watch properties that hold on every cycle. done lasts one cycle and follows a presented word. Presented words are never back to back. Memory requests never overlap execution. A start that hits the table never raises mem_req. Starts raised while busy leave the program base untouched. No two table entries hit at once. Only the bench scenarios can show the actual sequence of control fields for increment, jump and both branch outcomes. They also show section selection by phase, the number of words fetched on a miss or a full slot, which entry a miss evicts, and that pageable copies survive boot writes aimed at them.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  typedef enum logic [1:0] {
    NA_INC    = 2'd0,
    NA_JUMP   = 2'd1,
    NA_BRANCH = 2'd2,
    NA_END    = 2'd3
  } na_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_FETCH, S_WAIT, S_EXEC
  } seq_state_e;
endpackage

// File: rtl/ucseq_rtable.sv
module ucseq_rtable #(
  parameter int N_ENTRIES = 4,
  parameter int MADDR_W   = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_phase,
  input  logic [MADDR_W-1:0] lk_addr,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [IDX_W-1:0]   vic_idx,
  input  logic               alloc_en,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic               alloc_phase,
  input  logic [MADDR_W-1:0] alloc_addr,
  input  logic               commit_en,
  input  logic [IDX_W-1:0]   commit_idx,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx
);
  logic [N_ENTRIES-1:0] valid_q;
  logic [N_ENTRIES-1:0] tphase_q;
  logic [MADDR_W-1:0]   taddr_q [N_ENTRIES];
  logic [IDX_W-1:0]     age_q   [N_ENTRIES];
  logic [N_ENTRIES-1:0] hitv;
  logic [IDX_W-1:0]     use_idx;
  logic                 use_en;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hitv[g] = valid_q[g] && (tphase_q[g] == lk_phase) && (taddr_q[g] == lk_addr);
  end

  always_comb begin
    lk_hit = |hitv;
    lk_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (hitv[i]) lk_idx = IDX_W'(i);
  end

  // prefer an empty entry, else the oldest one
  always_comb begin
    vic_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (valid_q[i] && age_q[i] == IDX_W'(N_ENTRIES - 1)) vic_idx = IDX_W'(i);
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) vic_idx = IDX_W'(i);
  end

  assign use_en  = touch_en || commit_en;
  assign use_idx = touch_en ? touch_idx : commit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      tphase_q <= '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
        taddr_q[i] <= '0;
        age_q[i]   <= IDX_W'(i);
      end
    end else begin
      if (alloc_en) begin
        valid_q[alloc_idx]  <= 1'b0;
        tphase_q[alloc_idx] <= alloc_phase;
        taddr_q[alloc_idx]  <= alloc_addr;
      end
      if (commit_en) valid_q[commit_idx] <= 1'b1;
      if (use_en) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
          if (IDX_W'(i) == use_idx)       age_q[i] <= '0;
          else if (age_q[i] < age_q[use_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  // R8: a lookup never matches two entries
  p_single_match_r8: assert property (@(posedge clk) disable iff (rst) $onehot0(hitv));
endmodule

// File: rtl/ucseq_cstore.sv
module ucseq_cstore #(
  parameter int AW = 7,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucseq_pkg::*;
#(
  parameter int CTRL_W     = 8,
  parameter int MADDR_W    = 16,
  parameter int FIX_WORDS  = 32,
  parameter int SLOT_WORDS = 8,
  parameter int N_ENTRIES  = 4,
  localparam int SEC_AW    = $clog2(FIX_WORDS + N_ENTRIES * SLOT_WORDS),
  localparam int CS_AW     = SEC_AW + 1,
  localparam int UW        = 2 + CS_AW + CTRL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_rp,
  input  logic               start_phase,
  input  logic [MADDR_W-1:0] start_addr,
  input  logic               fu_status,
  output logic               fu_valid,
  output logic [CTRL_W-1:0]  fu_ctrl,
  output logic               done,
  output logic               busy,
  output logic               mem_req,
  output logic [MADDR_W-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [UW-1:0]      mem_rdata,
  input  logic               boot_we,
  input  logic [CS_AW-1:0]   boot_addr,
  input  logic [UW-1:0]      boot_data
);
  localparam int IDX_W   = $clog2(N_ENTRIES);
  localparam int SLOT_AW = $clog2(SLOT_WORDS);

  seq_state_e         state_q;
  logic [CS_AW-1:0]   csar_q, base_q, entry_addr, next_addr, ld_base;
  logic [UW-1:0]      mir_q, rd_word, ld_word, cs_wdata;
  logic               fu_valid_q, done_q;
  logic [IDX_W-1:0]   ld_idx_q;
  logic               ld_phase_q;
  logic [MADDR_W-1:0] ld_addr_q;
  logic [SLOT_AW-1:0] ld_cnt_q;
  logic               ld_we, ld_last, boot_ok, cs_we;
  logic [CS_AW-1:0]   cs_waddr;
  logic               lk_hit;
  logic [IDX_W-1:0]   lk_idx, vic_idx;
  logic               idle_start, alloc_en;
  na_mode_e           mir_mode, ld_mode;
  logic [CS_AW-1:0]   mir_tgt;

  function automatic logic [CS_AW-1:0] slot_base(input logic [IDX_W-1:0] idx, input logic ph);
    return {ph, SEC_AW'(FIX_WORDS + int'(idx) * SLOT_WORDS)};
  endfunction

  // microinstruction fields
  assign mir_mode = na_mode_e'(mir_q[UW-1 -: 2]);
  assign mir_tgt  = mir_q[CTRL_W +: CS_AW];
  assign ld_mode  = na_mode_e'(mem_rdata[UW-1 -: 2]);

  assign idle_start = (state_q == S_IDLE) && start;
  assign alloc_en   = idle_start && start_rp && !lk_hit;

  ucseq_rtable #(.N_ENTRIES(N_ENTRIES), .MADDR_W(MADDR_W)) u_table (
    .clk(clk), .rst(rst),
    .lk_phase(start_phase), .lk_addr(start_addr),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .vic_idx(vic_idx),
    .alloc_en(alloc_en), .alloc_idx(vic_idx),
    .alloc_phase(start_phase), .alloc_addr(start_addr),
    .commit_en(ld_we && ld_last), .commit_idx(ld_idx_q),
    .touch_en(idle_start && start_rp && lk_hit), .touch_idx(lk_idx)
  );

  // page loader write path
  assign ld_we   = (state_q == S_LOAD) && mem_ack;
  assign ld_last = (ld_mode == NA_END) || (ld_cnt_q == SLOT_AW'(SLOT_WORDS - 1));
  assign ld_base = slot_base(ld_idx_q, ld_phase_q);
  assign ld_word = ld_last ? {NA_END, mem_rdata[UW-3:0]} : mem_rdata;

  assign boot_ok  = boot_we && (boot_addr[SEC_AW-1:0] < SEC_AW'(FIX_WORDS)) && !ld_we;
  assign cs_we    = ld_we || boot_ok;
  assign cs_waddr = ld_we ? ld_base + CS_AW'(ld_cnt_q) : boot_addr;
  assign cs_wdata = ld_we ? ld_word : boot_data;

  ucseq_cstore #(.AW(CS_AW), .DW(UW)) u_store (
    .clk(clk), .we(cs_we), .waddr(cs_waddr), .wdata(cs_wdata),
    .raddr(csar_q), .rdata(rd_word)
  );

  always_comb begin
    if (!start_rp) entry_addr = {start_phase, start_addr[SEC_AW-1:0]};
    else           entry_addr = slot_base(lk_idx, start_phase);
  end

  always_comb begin
    unique case (mir_mode)
      NA_JUMP:   next_addr = base_q + mir_tgt;
      NA_BRANCH: next_addr = fu_status ? base_q + mir_tgt : csar_q + 1'b1;
      default:   next_addr = csar_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      csar_q     <= '0;
      base_q     <= '0;
      mir_q      <= '0;
      fu_valid_q <= 1'b0;
      done_q     <= 1'b0;
      ld_idx_q   <= '0;
      ld_phase_q <= 1'b0;
      ld_addr_q  <= '0;
      ld_cnt_q   <= '0;
    end else begin
      fu_valid_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          if (start_rp && !lk_hit) begin
            ld_idx_q   <= vic_idx;
            ld_phase_q <= start_phase;
            ld_addr_q  <= start_addr;
            ld_cnt_q   <= '0;
            state_q    <= S_LOAD;
          end else begin
            csar_q  <= entry_addr;
            base_q  <= entry_addr;
            state_q <= S_FETCH;
          end
        end
        S_LOAD: if (mem_ack) begin
          if (ld_last) begin
            csar_q  <= ld_base;
            base_q  <= ld_base;
            state_q <= S_FETCH;
          end else begin
            ld_cnt_q  <= ld_cnt_q + 1'b1;
            ld_addr_q <= ld_addr_q + 1'b1;
          end
        end
        S_FETCH: state_q <= S_WAIT;
        S_WAIT: begin
          mir_q      <= rd_word;
          fu_valid_q <= 1'b1;
          state_q    <= S_EXEC;
        end
        S_EXEC: begin
          if (mir_mode == NA_END) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            csar_q  <= next_addr;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign fu_valid = fu_valid_q;
  assign fu_ctrl  = mir_q[CTRL_W-1:0];
  assign done     = done_q;
  assign busy     = (state_q != S_IDLE);
  assign mem_req  = (state_q == S_LOAD);
  assign mem_addr = ld_addr_q;

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5: done follows a presented word and leaves the unit idle
  p_done_after_word_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(fu_valid) && !busy));
  // R2: presented words are spaced, never back to back
  p_word_spacing_r2: assert property (@(posedge clk) disable iff (rst) fu_valid |=> !fu_valid);
  // R6: memory traffic never overlaps execution
  p_req_not_exec_r6: assert property (@(posedge clk) disable iff (rst) !(mem_req && fu_valid));
  // R7: a table hit starts without a memory request
  p_hit_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    (idle_start && start_rp && lk_hit) |=> !mem_req);
  // R11: a start while busy leaves the program base unchanged
  p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
    (start && busy && state_q != S_LOAD) |=> $stable(base_q));
endmodule

// File: tb/tb_ucode_seq.sv
module tb_ucode_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, start_rp = 1'b0, start_phase = 1'b0;
  logic [15:0] start_addr = '0;
  logic        fu_status = 1'b0;
  logic        fu_valid, done, busy, mem_req, mem_ack;
  logic [7:0]  fu_ctrl;
  logic [15:0] mem_addr;
  logic [16:0] mem_rdata;
  logic        boot_we = 1'b0;
  logic [6:0]  boot_addr = '0;
  logic [16:0] boot_data = '0;
  logic [16:0] ext [0:255];

  int n_chk = 0, n_bad = 0;
  logic [7:0] tr [0:31];
  int tr_n, req_n, first_c, last_c, done_c, gap_bad;
  bit finished = 0;

  always #2 clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_rdata = ext[mem_addr[7:0]];

  ucode_seq dut (
    .clk(clk), .rst(rst), .start(start), .start_rp(start_rp), .start_phase(start_phase),
    .start_addr(start_addr), .fu_status(fu_status), .fu_valid(fu_valid), .fu_ctrl(fu_ctrl),
    .done(done), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .boot_we(boot_we), .boot_addr(boot_addr), .boot_data(boot_data)
  );

  function automatic logic [16:0] mkw(int mode, int tgt, int ctrl);
    return {2'(mode), 7'(tgt), 8'(ctrl)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic boot_write(int addr, logic [16:0] data);
    @(negedge clk);
    boot_we = 1'b1; boot_addr = 7'(addr); boot_data = data;
    @(negedge clk);
    boot_we = 1'b0;
  endtask

  // launch one program and record what the unit presents until done
  task automatic run_prog(bit rp, int addr, bit ph, bit st, bit intrude);
    tr_n = 0; req_n = 0; first_c = -1; last_c = -1; done_c = -1; gap_bad = 0;
    fu_status = st;
    @(negedge clk);
    start = 1'b1; start_rp = rp; start_addr = 16'(addr); start_phase = ph;
    for (int c = 1; c < 300; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (intrude && c == 2) begin
        start = 1'b1; start_rp = 1'b0; start_addr = 16'd0; start_phase = 1'b1;
      end
      if (mem_req) req_n++;
      if (fu_valid) begin
        if (first_c < 0) first_c = c;
        else if (c - last_c != 3) gap_bad++;
        last_c = c;
        if (tr_n < 32) tr[tr_n] = fu_ctrl;
        tr_n++;
      end
      if (done) begin done_c = c; break; end
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R5 single done pulse", {done, busy}, 0);
  endtask

  task automatic check_trace(string req, int n, logic [7:0] e0, logic [7:0] e1, logic [7:0] e2);
    logic [7:0] e [3];
    e[0] = e0; e[1] = e1; e[2] = e2;
    check(tr_n == n, req, tr_n, n);
    for (int i = 0; i < n && i < tr_n; i++) check(tr[i] == e[i], req, tr[i], e[i]);
    check(done_c == last_c + 1, "R5 done timing", done_c, last_c + 1);
  endtask

  task automatic t_reset();
    check(!busy && !fu_valid && !done && !mem_req, "R1 reset state",
          {busy, fu_valid, done, mem_req}, 0);
  endtask

  task automatic t_direct();
    run_prog(0, 0, 0, 0, 0);
    check_trace("R3 inc and jump", 3, 8'h11, 8'h12, 8'h13);
    check(first_c == 3, "R2 first word latency", first_c, 3);
    check(gap_bad == 0, "R2 word spacing", gap_bad, 0);
    check(req_n == 0, "R2 no memory traffic", req_n, 0);
  endtask

  task automatic t_branch();
    run_prog(0, 8, 0, 1, 0);
    check_trace("R4 branch taken", 2, 8'h21, 8'h23, 8'h00);
    run_prog(0, 8, 0, 0, 0);
    check_trace("R4 branch not taken", 2, 8'h21, 8'h22, 8'h00);
  endtask

  task automatic t_section();
    run_prog(0, 0, 1, 0, 0);
    check_trace("R2 execute section", 1, 8'h31, 8'h00, 8'h00);
  endtask

  task automatic t_miss_hit();
    run_prog(1, 16'h10, 0, 0, 0);
    check(req_n == 4, "R6 words fetched on miss", req_n, 4);
    check_trace("R6 paged program runs", 3, 8'h41, 8'h42, 8'h43);
    run_prog(1, 16'h10, 0, 0, 0);
    check(req_n == 0, "R7 hit fetches nothing", req_n, 0);
    check_trace("R7 resident copy runs", 3, 8'h41, 8'h42, 8'h43);
  endtask

  task automatic t_lru();
    run_prog(1, 16'h20, 0, 0, 0);
    run_prog(1, 16'h30, 0, 0, 0);
    run_prog(1, 16'h40, 0, 0, 0);
    check(req_n == 1 && tr[0] == 8'h54, "R8 fill empty entries", req_n, 1);
    run_prog(1, 16'h10, 0, 0, 0);
    check(req_n == 0, "R8 entry kept while table fills", req_n, 0);
    run_prog(1, 16'h50, 0, 0, 0);
    check(req_n == 1 && tr[0] == 8'h55, "R8 miss on full table", req_n, 1);
    run_prog(1, 16'h30, 0, 0, 0);
    check(req_n == 0, "R8 newer entry survives", req_n, 0);
    run_prog(1, 16'h10, 0, 0, 0);
    check(req_n == 0, "R8 recently used survives", req_n, 0);
    run_prog(1, 16'h20, 0, 0, 0);
    check(req_n == 1, "R8 least recent was evicted", req_n, 1);
    run_prog(1, 16'h50, 0, 0, 0);
    check(req_n == 0, "R8 entry kept after eviction", req_n, 0);
  endtask

  task automatic t_phase_tag();
    run_prog(1, 16'h10, 1, 0, 0);
    check(req_n == 4, "R9 other phase misses", req_n, 4);
    check_trace("R9 copy in execute section", 3, 8'h41, 8'h42, 8'h43);
  endtask

  task automatic t_slot_full();
    run_prog(1, 16'h80, 0, 0, 0);
    check(req_n == 8, "R10 copy stops at slot size", req_n, 8);
    check(tr_n == 8, "R10 last word ends program", tr_n, 8);
    for (int i = 0; i < 8 && i < tr_n; i++) check(tr[i] == 8'(8'h60 + i), "R10 slot words", tr[i], 8'h60 + i);
  endtask

  task automatic t_busy_start();
    run_prog(0, 0, 0, 0, 1);
    check_trace("R11 start ignored while busy", 3, 8'h11, 8'h12, 8'h13);
    repeat (6) begin
      @(negedge clk);
      check(!fu_valid && !busy, "R11 no queued program", {fu_valid, busy}, 0);
    end
  endtask

  task automatic t_boot_ignore();
    for (int s = 0; s < 2; s++)
      for (int o = 32; o < 64; o++) boot_write(s * 64 + o, mkw(3, 0, 8'hFF));
    run_prog(1, 16'h80, 0, 0, 0);
    check(req_n == 0, "R12 entry still resident", req_n, 0);
    check(tr_n == 8, "R12 pageable copy untouched", tr_n, 8);
    for (int i = 0; i < 8 && i < tr_n; i++) check(tr[i] == 8'(8'h60 + i), "R12 pageable words", tr[i], 8'h60 + i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) ext[i] = mkw(3, 0, 8'hEE);
    ext[8'h10] = mkw(0, 0, 8'h41); ext[8'h11] = mkw(1, 3, 8'h42);
    ext[8'h12] = mkw(0, 0, 8'hEE); ext[8'h13] = mkw(3, 0, 8'h43);
    ext[8'h20] = mkw(3, 0, 8'h52); ext[8'h30] = mkw(3, 0, 8'h53);
    ext[8'h40] = mkw(3, 0, 8'h54); ext[8'h50] = mkw(3, 0, 8'h55);
    for (int i = 0; i < 8; i++) ext[8'h80 + i] = mkw(0, 0, 8'h60 + i);
    ext[8'h88] = mkw(3, 0, 8'h68);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    boot_write(0, mkw(0, 0, 8'h11)); boot_write(1, mkw(1, 3, 8'h12));
    boot_write(2, mkw(0, 0, 8'hEE)); boot_write(3, mkw(3, 0, 8'h13));
    boot_write(8, mkw(2, 2, 8'h21)); boot_write(9, mkw(3, 0, 8'h22));
    boot_write(10, mkw(3, 0, 8'h23));
    boot_write(64, mkw(3, 0, 8'h31));
    t_direct();
    t_branch();
    t_section();
    t_miss_hit();
    t_lru();
    t_phase_tag();
    t_slot_full();
    t_busy_start();
    t_boot_ignore();
    report();
  end
endmodule